// File: doc/BRIEF.md
# Countdown Register Scoreboard Stall Unit

This unit sits in front of an in-order issue point and decides, once per clock, whether the micro-op on its input may go or must wait. For every architectural register it keeps a small down-counter that holds how many cycles remain before that register's value can be read. A counter at zero means the value is available. Every counter that is above zero drops by one on each clock, whether or not anything issues.

A micro-op carries two source specifiers, one destination specifier and a load flag. Each specifier is a valid bit plus an index, and index 63 also stands for "no register". The micro-op issues only when every source it uses has a counter at zero. When it issues with a destination, that destination's counter is armed with the operation's latency. A load uses a runtime latency from 1 to 15 cycles, and every other operation uses a latency of 1. Within a cycle the arming takes effect before that cycle's decrement, so a single-cycle result is usable by the very next micro-op. A stalled micro-op stays on the input until it issues.

Two saturating statistics counters record elapsed clock cycles and issued micro-ops, for use in CPI measurements.

Top module: `regcd_stall_unit`

## Requirements
- R1: While reset is asserted and on release, all register counters read as zero, so any micro-op is ready. The cycle count and the issue count are zero.
- R2: A non-zero register counter decreases by one every clock whether or not anything issues. A load of latency n, 2 to 15, stalls a directly following micro-op that reads its destination for exactly n-1 cycles.
- R3: in_ready is high exactly when every used source has a zero counter, and a micro-op issues when in_valid and in_ready are both high. A stalled micro-op is held on the input and issues in a later cycle.
- R4: A non-load micro-op that writes register d lets a directly following micro-op that reads d issue with no stall.
- R5: A specifier is unused when its valid bit is 0 or its index is 63. An unused source is always ready, and an unused destination changes no counter.
- R6: A micro-op that does not read a pending load's destination issues with no stall. The cycle it takes still counts down the load's remaining latency.
- R7: cycle_cnt increases by one on every clock after reset and holds at its all-ones value instead of wrapping.
- R8: issue_cnt increases by one for each issued micro-op, holds when nothing issues, and saturates at all-ones.
- R9: A load_lat value of 0 is treated as 1. The latency is taken when the load issues, so a later change of load_lat does not affect a register that is already counting.
- R10: While in_valid is low, nothing issues and no counter is armed, but the countdown continues.
- R11: A write to a register whose counter is still running replaces the remaining count with the new operation's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A micro-op is presented |
| src_a_vld | input | 1 | Source A is used |
| src_a_idx | input | 6 | Source A register index (63 = none) |
| src_b_vld | input | 1 | Source B is used |
| src_b_idx | input | 6 | Source B register index (63 = none) |
| dst_vld | input | 1 | Destination is written |
| dst_idx | input | 6 | Destination register index (63 = none) |
| is_load | input | 1 | Micro-op is a load |
| load_lat | input | LAT_W (4) | Load latency in cycles, 0 treated as 1 |
| in_ready | output | 1 | Sources ready; with in_valid, the micro-op issues |
| cycle_cnt | output | STAT_W (32) | Saturating count of clock cycles |
| issue_cnt | output | STAT_W (32) | Saturating count of issued micro-ops |

## Verification
The bench builds the unit with STAT_W set to 8 and the default 4-bit latency and 6-bit register index. The narrow statistics width lets a run of a few hundred micro-ops drive both counters into saturation. The 4-bit latency covers the full 1 to 15 range, including the longest stall of 14 cycles. The 6-bit index allows the reserved index 63 to be exercised as both a source and a destination.

// File: rtl/regcd_pkg.sv
package regcd_pkg;
  parameter int unsigned REG_IDX_W = 6;

  // A specifier is live when flagged valid and not the reserved all-ones index
  function automatic logic spec_used(input logic vld, input logic [REG_IDX_W-1:0] idx);
    return vld && (idx != {REG_IDX_W{1'b1}});
  endfunction
endpackage

// File: rtl/regcd_cnt_bank.sv
module regcd_cnt_bank
  import regcd_pkg::*;
#(
  parameter int unsigned LAT_W = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [REG_IDX_W-1:0]                  wr_idx,
  input  logic [LAT_W-1:0]                      wr_val,
  output logic [(1<<REG_IDX_W)-1:0][LAT_W-1:0]  cnt_q
);
  localparam int unsigned NUM_REGS = 1 << REG_IDX_W;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    localparam logic [REG_IDX_W-1:0] MY_IDX = REG_IDX_W'(i);
    logic             hit;
    logic [LAT_W-1:0] cnt_d;

    always_comb begin
      hit = wr_en && (wr_idx == MY_IDX);
      if (hit) begin
        cnt_d = wr_val;
      end else if (cnt_q[i] != '0) begin
        cnt_d = cnt_q[i] - 1'b1;
      end else begin
        cnt_d = cnt_q[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
      end else begin
        cnt_q[i] <= cnt_d;
      end
    end

    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] != '0 && !hit) |=> (cnt_q[i] == $past(cnt_q[i]) - 1'b1));
  end
endmodule

// File: rtl/regcd_src_check.sv
module regcd_src_check
  import regcd_pkg::*;
#(
  parameter int unsigned LAT_W = 4
) (
  input  logic [(1<<REG_IDX_W)-1:0][LAT_W-1:0] cnt_q,
  input  logic                                 a_vld,
  input  logic [REG_IDX_W-1:0]                 a_idx,
  input  logic                                 b_vld,
  input  logic [REG_IDX_W-1:0]                 b_idx,
  output logic                                 srcs_ready
);
  logic a_ok;
  logic b_ok;

  always_comb begin
    a_ok       = !spec_used(a_vld, a_idx) || (cnt_q[a_idx] == '0);
    b_ok       = !spec_used(b_vld, b_idx) || (cnt_q[b_idx] == '0);
    srcs_ready = a_ok && b_ok;
  end
endmodule

// File: rtl/regcd_sat_cnt.sv
module regcd_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         at_max;

  always_comb begin
    at_max = (q == {W{1'b1}});
    q_d    = (inc && !at_max) ? q + 1'b1 : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

  // R7 R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q == {W{1'b1}}) |=> (q == {W{1'b1}}));
endmodule

// File: rtl/regcd_stall_unit.sv
module regcd_stall_unit
  import regcd_pkg::*;
#(
  parameter int unsigned LAT_W  = 4,
  parameter int unsigned STAT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 src_a_vld,
  input  logic [REG_IDX_W-1:0] src_a_idx,
  input  logic                 src_b_vld,
  input  logic [REG_IDX_W-1:0] src_b_idx,
  input  logic                 dst_vld,
  input  logic [REG_IDX_W-1:0] dst_idx,
  input  logic                 is_load,
  input  logic [LAT_W-1:0]     load_lat,
  output logic                 in_ready,
  output logic [STAT_W-1:0]    cycle_cnt,
  output logic [STAT_W-1:0]    issue_cnt
);
  localparam int unsigned NUM_REGS = 1 << REG_IDX_W;

  logic [NUM_REGS-1:0][LAT_W-1:0] cnt_q;
  logic                           srcs_ready;
  logic                           issue;
  logic                           wr_en;
  logic [LAT_W-1:0]               lat_eff;
  logic [LAT_W-1:0]               wr_val;

  regcd_src_check #(.LAT_W(LAT_W)) u_src (
    .cnt_q      (cnt_q),
    .a_vld      (src_a_vld),
    .a_idx      (src_a_idx),
    .b_vld      (src_b_vld),
    .b_idx      (src_b_idx),
    .srcs_ready (srcs_ready)
  );

  always_comb begin
    issue    = in_valid && srcs_ready;
    in_ready = srcs_ready;
    wr_en    = issue && spec_used(dst_vld, dst_idx);
    if (is_load && (load_lat != '0)) begin
      lat_eff = load_lat;
    end else begin
      lat_eff = LAT_W'(1);
    end
    // arming happens ahead of this cycle's decrement
    wr_val = lat_eff - 1'b1;
  end

  regcd_cnt_bank #(.LAT_W(LAT_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (dst_idx),
    .wr_val (wr_val),
    .cnt_q  (cnt_q)
  );

  regcd_sat_cnt #(.W(STAT_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (1'b1),
    .q     (cycle_cnt)
  );

  regcd_sat_cnt #(.W(STAT_W)) u_iss (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (issue),
    .q     (issue_cnt)
  );

  // R2
  load_dep_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && spec_used(dst_vld, dst_idx) && is_load && (load_lat > LAT_W'(1)))
    |=> !(spec_used(src_a_vld, src_a_idx) && (src_a_idx == $past(dst_idx)) && in_ready));

  // R4
  alu_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && spec_used(dst_vld, dst_idx) && !is_load)
    |=> ((spec_used(src_a_vld, src_a_idx) && (src_a_idx == $past(dst_idx))
          && !spec_used(src_b_vld, src_b_idx)) -> in_ready));

  // R8
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(issue_cnt));

  // R7
  cyc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_cnt != {STAT_W{1'b1}}) |=> (cycle_cnt == $past(cycle_cnt) + 1'b1));
endmodule

// File: tb/regcd_stall_unit_tb.sv
`timescale 1ns/1ps
module regcd_stall_unit_tb;
  localparam int STAT_W = 8;
  localparam int SMAX   = 255;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, src_a_vld, src_b_vld, dst_vld, is_load;
  logic [5:0] src_a_idx, src_b_idx, dst_idx;
  logic [3:0] load_lat;
  logic       in_ready;
  logic [STAT_W-1:0] cycle_cnt, issue_cnt;

  int checks = 0;
  int errors = 0;
  int sb[64];
  int m_cyc = 0;
  int m_iss = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regcd_stall_unit #(.LAT_W(4), .STAT_W(STAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
    .src_b_vld(src_b_vld), .src_b_idx(src_b_idx),
    .dst_vld(dst_vld), .dst_idx(dst_idx), .is_load(is_load),
    .load_lat(load_lat), .in_ready(in_ready),
    .cycle_cnt(cycle_cnt), .issue_cnt(issue_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit m_used(input bit v, input int idx);
    return v && (idx != 63);
  endfunction

  function automatic bit m_ready(input bit av, input int ai, input bit bv, input int bi);
    return (!m_used(av, ai) || sb[ai] == 0) && (!m_used(bv, bi) || sb[bi] == 0);
  endfunction

  // One clock: drive at falling edge, compare, then advance the model past the rising edge
  task automatic do_cycle(input bit v, input bit av, input int ai, input bit bv, input int bi,
                          input bit dv, input int di, input bit ld, input int lat,
                          output bit issued);
    bit er;
    int le;
    in_valid = v; src_a_vld = av; src_a_idx = 6'(ai); src_b_vld = bv; src_b_idx = 6'(bi);
    dst_vld = dv; dst_idx = 6'(di); is_load = ld; load_lat = 4'(lat);
    #2;
    er = m_ready(av, ai, bv, bi);
    check(in_ready == er, "R3 in_ready", int'(in_ready), int'(er));
    check(int'(cycle_cnt) == m_cyc, "R7 cycle_cnt", int'(cycle_cnt), m_cyc);
    check(int'(issue_cnt) == m_iss, "R8 issue_cnt", int'(issue_cnt), m_iss);
    @(posedge clk);
    issued = v && er;
    le = ld ? ((lat == 0) ? 1 : lat) : 1;
    for (int i = 0; i < 64; i++) begin
      if (issued && m_used(dv, di) && i == di) sb[i] = le - 1;
      else if (sb[i] > 0) sb[i]--;
    end
    if (m_cyc < SMAX) m_cyc++;
    if (issued && m_iss < SMAX) m_iss++;
    @(negedge clk);
  endtask

  task automatic issue_op(input bit av, input int ai, input bit bv, input int bi,
                          input bit dv, input int di, input bit ld, input int lat,
                          input int exp_stalls, input string req);
    bit iss;
    int stalls = 0;
    for (int k = 0; k < 40; k++) begin
      do_cycle(1'b1, av, ai, bv, bi, dv, di, ld, lat, iss);
      if (iss) break;
      stalls++;
    end
    check(stalls == exp_stalls, req, stalls, exp_stalls);
  endtask

  task automatic idle(input int n);
    bit iss;
    for (int k = 0; k < n; k++) do_cycle(1'b0, 1'b1, 13, 1'b0, 0, 1'b1, 20, 1'b1, 7, iss);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) sb[i] = 0;
    rst_n = 1'b0;
    in_valid = 1'b0; src_a_vld = 1'b1; src_a_idx = 6'd1; src_b_vld = 1'b1; src_b_idx = 6'd2;
    dst_vld = 1'b0; dst_idx = 6'd0; is_load = 1'b0; load_lat = 4'd1;
    repeat (3) @(negedge clk);
    #2;
    check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    check(cycle_cnt == '0, "R1 cycle_cnt reset", int'(cycle_cnt), 0);
    check(issue_cnt == '0, "R1 issue_cnt reset", int'(issue_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 first op issues straight away
    issue_op(1, 1, 1, 2, 1, 3, 0, 1, 0, "R1 first issue");
    // R4 single-cycle producer feeds next op
    issue_op(1, 3, 0, 0, 0, 0, 0, 1, 0, "R4 alu dependent");
    issue_op(1, 4, 0, 0, 1, 4, 0, 1, 0, "R4 alu producer");
    issue_op(0, 0, 1, 4, 0, 0, 0, 1, 0, "R4 alu dep src_b");
    // R2 load latencies
    issue_op(0, 0, 0, 0, 1, 5, 1, 4, 0, "R2 load lat4");
    issue_op(1, 5, 0, 0, 0, 0, 0, 1, 3, "R2 dep after lat4");
    issue_op(0, 0, 0, 0, 1, 6, 1, 1, 0, "R2 load lat1");
    issue_op(1, 6, 0, 0, 0, 0, 0, 1, 0, "R2 dep after lat1");
    issue_op(0, 0, 0, 0, 1, 8, 1, 15, 0, "R2 load lat15");
    issue_op(1, 9, 1, 8, 0, 0, 0, 1, 14, "R2 dep src_b after lat15");
    // R6 independent op fills the slot
    issue_op(0, 0, 0, 0, 1, 7, 1, 6, 0, "R6 load lat6");
    issue_op(1, 1, 0, 0, 1, 2, 0, 1, 0, "R6 independent op");
    issue_op(1, 7, 0, 0, 0, 0, 0, 1, 4, "R6 dep after filler");
    // R5 unused specifiers
    issue_op(0, 0, 0, 0, 1, 7, 1, 8, 0, "R5 load lat8");
    issue_op(0, 7, 0, 0, 0, 0, 0, 1, 0, "R5 src vld=0");
    issue_op(1, 63, 1, 63, 0, 0, 0, 1, 0, "R5 src idx 63");
    issue_op(1, 7, 0, 0, 0, 0, 0, 1, 5, "R5 real dep still stalls");
    issue_op(0, 0, 0, 0, 0, 10, 1, 9, 0, "R5 dst vld=0 load");
    issue_op(1, 10, 0, 0, 0, 0, 0, 1, 0, "R5 dst vld=0 no effect");
    issue_op(0, 0, 0, 0, 1, 63, 1, 9, 0, "R5 dst idx 63 load");
    issue_op(1, 10, 1, 11, 0, 0, 0, 1, 0, "R5 dst idx 63 no effect");
    // R9 latency handling
    issue_op(0, 0, 0, 0, 1, 11, 1, 0, 0, "R9 load lat0");
    issue_op(1, 11, 0, 0, 0, 0, 0, 1, 0, "R9 lat0 acts as 1");
    issue_op(0, 0, 0, 0, 1, 12, 1, 5, 0, "R9 load lat5");
    issue_op(1, 12, 0, 0, 0, 0, 0, 15, 4, "R9 later lat change ignored");
    // R10 idle cycles keep counting down
    issue_op(0, 0, 0, 0, 1, 13, 1, 8, 0, "R10 load lat8");
    idle(3);
    issue_op(1, 13, 0, 0, 0, 0, 0, 1, 4, "R10 dep after idle");
    check(sb[20] == 0, "R10 idle did not arm", sb[20], 0);
    issue_op(1, 20, 0, 0, 0, 0, 0, 1, 0, "R10 idle dst untouched");
    // R11 overwrite of a pending counter
    issue_op(0, 0, 0, 0, 1, 14, 1, 12, 0, "R11 load lat12");
    issue_op(1, 1, 0, 0, 1, 14, 0, 1, 0, "R11 alu overwrite");
    issue_op(1, 14, 0, 0, 0, 0, 0, 1, 0, "R11 dep after overwrite");
    issue_op(0, 0, 0, 0, 1, 15, 0, 1, 0, "R11 alu first");
    issue_op(0, 0, 0, 0, 1, 15, 1, 7, 0, "R11 load overwrite");
    issue_op(1, 15, 0, 0, 0, 0, 0, 1, 6, "R11 dep after load overwrite");
    // R7 R8 saturation
    for (int k = 0; k < 270; k++) begin
      bit iss;
      do_cycle(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 30, 1'b0, 1, iss);
    end
    #2;
    check(int'(cycle_cnt) == SMAX, "R7 cycle_cnt saturated", int'(cycle_cnt), SMAX);
    check(int'(issue_cnt) == SMAX, "R8 issue_cnt saturated", int'(issue_cnt), SMAX);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule